// File: doc/BRIEF.md
# Marker-Bit Serial Transmitter

This block is an asynchronous serial transmitter. It sends either a 10-bit frame (start bit, eight data bits, stop bit) or an 11-bit frame that carries a programmable ninth bit between the data byte and the stop bit. A single write strobe hands over a byte and the ninth bit. The block then shifts them out least significant bit first on the line output. When the frame is complete it raises a sticky done flag.

Bit timing comes from a free-running divide-by-16 counter, which advances on a one-cycle 16x-baud enable pulse. A write does not start the frame. It only posts a request, and the start bit appears on the next rollover of the counter, so every bit boundary follows that counter. The block does not count bits to find the end of the frame. A marker '1' travels down a zero-filled shift register, and its arrival just above the output position ends the frame.

Top module: `uart_marker_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `txd` = 1, `tx_done` = 0, and the divide-by-16 counter is 0.
- R2: A rollover is the sixteenth `tick16` pulse counted from reset, and every sixteenth pulse after that. The start bit appears on the first rollover strictly after an accepted write. A write made in the same cycle as a rollover starts on the following rollover.
- R3: The start bit drives `txd` = 0 for exactly one bit time, which is 16 `tick16` pulses.
- R4: After the start bit, the eight bits of `wr_data` appear on `txd` one bit time each, bit 0 first.
- R5: When `mode11` = 1 at the write, the bit `bit9_in` follows data bit 7 for one bit time. When `mode11` = 0, no extra bit is sent.
- R6: `tx_done` rises, and `txd` returns to 1 (stop bit), on the 10th rollover after the write in 10-bit mode and on the 11th in 11-bit mode.
- R7: `tx_done` stays at 1 until a cycle with `done_clr` = 1 clears it. If the flag is set and cleared in the same cycle, setting wins.
- R8: A write while a frame is pending or in progress has no effect on the frame being sent.
- R9: `mode11` and `bit9_in` are used only in the cycle of an accepted write. Changes at any other time do not alter the frame.
- R10: Outside the start, data and ninth-bit times, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| wr_en | input | 1 | Write strobe for a new frame |
| wr_data | input | 8 | Data byte, sent LSB first |
| bit9_in | input | 1 | Ninth bit for 11-bit frames |
| mode11 | input | 1 | 1 selects 11-bit frames, 0 selects 10-bit frames |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line, idle high |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
Two functions can fall in one cycle. The end of a frame sets the done flag, and a software clear pulse can arrive in that same cycle. The bench model predicts the exact edge at which the final rollover lands and raises `done_clr` in that cycle only. The flag must then read 1 afterwards. A write coinciding with a rollover is provoked the same way, and its start bit must appear only one full bit time later.

// File: rtl/uart_tx_pkg.sv
// Package: shared types for the marker-bit serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_tx_pkg;

    // Frame sequencer phase.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // line high, ready for a write
        PH_WAIT  = 2'd1,   // write taken, waiting for a rollover
        PH_START = 2'd2,   // start bit on the line
        PH_DATA  = 2'd3    // shift register drives the line
    } tx_phase_t;

endpackage

// File: rtl/utx_div16.sv
// Module: utx_div16
// Free-running bit-time divider. It counts 16x-baud enable pulses and
// flags the cycle in which the count wraps, which is one bit boundary.
// Assumes: tick16 is a single-cycle pulse; reset is synchronous, active low.
module utx_div16 #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    output logic roll
);
    localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt;

    // Advance the counter on every enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick16)
            cnt <= cnt + 1'b1;
    end

    // A bit boundary is the pulse that wraps the counter.
    assign roll = tick16 && (cnt == CNT_MAX);

    AST_ROLL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> (cnt == '0)); // R2

endmodule

// File: rtl/utx_shifter.sv
// Module: utx_shifter
// Transmit shift register. A load fills the byte and the ninth position.
// A shift moves toward the output bit and inserts the fill bit at the top.
// The marker output is high when only a single '1' sits just above the
// output bit.
// Assumes: load and shift never occur in the same cycle.
module utx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_top,
    input  logic              shift,
    input  logic              fill,
    output logic              out_bit,
    output logic              marker
);
    localparam int SR_W = DATA_W + 1;

    logic [SR_W-1:0] sr;

    // Load a new frame or move one position toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= {load_top, load_data};
        else if (shift)
            sr <= {fill, sr[SR_W-1:1]};
    end

    // The output position is bit 0; the marker test looks above it.
    assign out_bit = sr[0];
    assign marker  = sr[1] && (sr[SR_W-1:2] == '0);

    AST_SR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sr)); // R8

endmodule

// File: rtl/utx_seq.sv
// Module: utx_seq
// Frame sequencer. It takes a write when idle and waits for a bit boundary.
// It then sends the start bit and hands the line to the shift register.
// It ends the frame when the marker is seen after the first shift.
// Assumes: roll marks bit boundaries; marker/out_bit come from utx_shifter.
module utx_seq
    import uart_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic roll,
    input  logic wr_en,
    input  logic mode11,
    input  logic done_clr,
    input  logic marker,
    input  logic out_bit,
    output logic load,
    output logic shift,
    output logic fill,
    output logic txd,
    output logic tx_done
);
    tx_phase_t phase;
    logic      shifted;
    logic      mode_q;
    logic      done_q;
    logic      finish;

    // A write is taken only when the line is idle.
    assign load   = wr_en && (phase == PH_IDLE);
    // Every data-phase boundary shifts, including the final one.
    assign shift  = roll && (phase == PH_DATA);
    assign finish = shift && shifted && marker;
    // The stop bit enters at the top on the first shift of an 11-bit frame.
    assign fill   = mode_q && !shifted;

    // Phase, first-shift and mode bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shifted <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (wr_en) begin
                    phase  <= PH_WAIT;
                    mode_q <= mode11;
                end
                PH_WAIT:  if (roll) phase <= PH_START;
                PH_START: if (roll) begin
                    phase   <= PH_DATA;
                    shifted <= 1'b0;
                end
                PH_DATA: if (roll) begin
                    if (finish) phase <= PH_IDLE;
                    shifted <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Sticky done flag; a new completion outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (finish)
            done_q <= 1'b1;
        else if (done_clr)
            done_q <= 1'b0;
    end

    // Line driver: low for start, register bit for data, high otherwise.
    always_comb begin
        case (phase)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = out_bit;
            default:  txd = 1'b1;
        endcase
    end

    assign tx_done = done_q;

    AST_START_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START && $past(phase) != PH_START) |-> $past(roll)); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START) |-> !txd); // R3
    AST_DONE_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(roll)); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !done_clr) |=> done_q); // R7
    AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |-> txd); // R10

endmodule

// File: rtl/uart_marker_tx.sv
// Module: uart_marker_tx
// Top of the marker-bit serial transmitter: divider, sequencer, shifter.
// Assumes: a single clock; tick16 is a one-cycle pulse at 16x the baud rate.
module uart_marker_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit9_in,
    input  logic              mode11,
    input  logic              done_clr,
    output logic              txd,
    output logic              tx_done
);
    logic roll;
    logic load;
    logic shift;
    logic fill;
    logic out_bit;
    logic marker;
    logic load_top;

    // In 10-bit frames the top position holds the stop bit from the start.
    assign load_top = mode11 ? bit9_in : 1'b1;

    utx_div16 #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick16 (tick16),
        .roll   (roll)
    );

    utx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .roll     (roll),
        .wr_en    (wr_en),
        .mode11   (mode11),
        .done_clr (done_clr),
        .marker   (marker),
        .out_bit  (out_bit),
        .load     (load),
        .shift    (shift),
        .fill     (fill),
        .txd      (txd),
        .tx_done  (tx_done)
    );

    utx_shifter #(.DATA_W(DATA_W)) u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (wr_data),
        .load_top  (load_top),
        .shift     (shift),
        .fill      (fill),
        .out_bit   (out_bit),
        .marker    (marker)
    );

endmodule

// File: tb/uart_marker_tx_test.sv
`timescale 1ns/1ps
module uart_marker_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit9_in = 1'b0;
    logic       mode11 = 1'b0;
    logic       done_clr = 1'b0;
    logic       txd;
    logic       tx_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Behavioural reference state.
    int          mcnt = 0;
    int          mph = 0;        // 0 idle, 1 waiting, 2 sending
    int          mk = 0;         // bit index within the frame
    int          mn = 9;         // index at which the frame ends
    logic [10:0] mframe = '0;
    logic        mdone = 1'b0;
    logic        mfin = 1'b0;

    // Stimulus control.
    int    tdiv = 2;
    int    tphase = 0;
    bit    clr_at_finish = 1'b0;
    bit    wr_at_roll = 1'b0;
    string ctx = "";

    uart_marker_tx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
        .wr_data(wr_data), .bit9_in(bit9_in), .mode11(mode11),
        .done_clr(done_clr), .txd(txd), .tx_done(tx_done)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Reference model, updated at each rising edge.
    always @(posedge clk) begin
        bit roll_now;
        cycles++;
        mfin = 1'b0;
        if (!rst_n) begin
            mcnt = 0; mph = 0; mk = 0; mdone = 1'b0;
        end else begin
            roll_now = tick16 && (mcnt == 15);
            if (tick16) mcnt = (mcnt + 1) % 16;
            case (mph)
                0: if (wr_en) begin
                    mph = 1;
                    mn = mode11 ? 10 : 9;
                    mframe = {(mode11 ? bit9_in : 1'b1), wr_data, 1'b0};
                end
                1: if (roll_now) begin mph = 2; mk = 0; end
                default: if (roll_now) begin
                    mk++;
                    if (mk == mn) begin mph = 0; mfin = 1'b1; end
                end
            endcase
            if (mfin) mdone = 1'b1;
            else if (done_clr) mdone = 1'b0;
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            string tag;
            logic  exp_txd;
            exp_txd = (mph == 2) ? mframe[mk] : 1'b1;
            if (ctx != "")        tag = ctx;
            else if (mph == 0)    tag = mfin ? "R6" : "R10";
            else if (mph == 1)    tag = "R2";
            else if (mk == 0)     tag = "R3";
            else if (mk <= 8)     tag = "R4";
            else                  tag = "R5";
            check(tag, txd, exp_txd);
            check(mfin ? "R6" : "R7", tx_done, mdone);
        end
    end

    // Watchdog.
    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    // One stimulus cycle, driven at the falling edge.
    task automatic step(input bit wr, input logic [7:0] d, input bit b9,
                        input bit m11, input bit clr);
        @(negedge clk);
        tick16 = (tphase == 0);
        tphase = (tphase + 1) % tdiv;
        wr_data = d; bit9_in = b9; mode11 = m11;
        wr_en = wr;
        if (wr_at_roll && tick16 && mcnt == 15 && mph == 0) begin
            wr_en = 1'b1; wr_at_roll = 1'b0;
        end
        done_clr = clr;
        if (clr_at_finish && mph == 2 && tick16 && mcnt == 15 && mk + 1 == mn)
            done_clr = 1'b1;
    endtask

    // Run until the model returns to idle; noisy mode pokes inputs mid-frame.
    task automatic wait_frame(input bit noisy);
        for (int i = 0; i < 4000 && mph != 0; i++) begin
            if (noisy) step((i % 7) == 3, 8'hFF ^ 8'(i), i[0], i[1], 1'b0);
            else       step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        end
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic frame(input logic [7:0] d, input bit b9, input bit m11, input bit noisy);
        step(1'b1, d, b9, m11, 1'b0);
        wait_frame(noisy);
    endtask

    initial begin
        repeat (3) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle after reset
        check("R1", txd, 1'b1);
        check("R1", tx_done, 1'b0);

        frame(8'hA5, 1'b0, 1'b0, 1'b0);          // R4 R6 10-bit
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);     // R7 clear
        frame(8'h3C, 1'b1, 1'b1, 1'b0);          // R5 11-bit, ninth=1
        tdiv = 1;
        frame(8'h02, 1'b0, 1'b1, 1'b0);          // marker corner, ninth=0
        frame(8'h00, 1'b0, 1'b0, 1'b0);
        frame(8'hFF, 1'b1, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);

        ctx = "R8";                              // writes while busy
        frame(8'h5A, 1'b0, 1'b1, 1'b1);
        ctx = "R9";                              // mode and ninth bit toggling
        frame(8'hC3, 1'b1, 1'b0, 1'b1);
        ctx = "";

        tdiv = 3;
        wr_at_roll = 1'b1;                       // R2 write on a rollover
        for (int i = 0; i < 200 && (wr_at_roll || mph != 0); i++)
            step(1'b0, 8'h96, 1'b1, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

        clr_at_finish = 1'b1;                    // R7 set wins over clear
        frame(8'h81, 1'b0, 1'b0, 1'b0);
        clr_at_finish = 1'b0;
        check("R7", tx_done, 1'b1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R7", tx_done, 1'b0);

        rst_n = 1'b0;                            // R1 reset mid-frame
        step(1'b1, 8'h11, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R1", txd, 1'b1);
        check("R1", tx_done, 1'b0);
        finish_run();
    end
endmodule